// File: doc/BRIEF.md
# Interrupt Expander Controller

This block gathers a bank of external interrupt request lines into a single active-high, level-sensitive interrupt for a host processor. Each request line has its own sticky pending flag and its own enable bit. The output stays high while any enabled line has its flag set.

Software reaches the block through a small word-wide register port with four locations:
- the sticky pending flags, cleared by writing ones;
- a live view of the request lines, with no latching and no masking;
- an enable-set location;
- an enable-clear location.

Enable changes are single atomic writes of a bit pattern, so no read-modify-write is needed. Both enable locations read back the enable vector with no side effect, so software can flush a posted write by reading the enable-clear location.

The request lines pass through a parameterised synchroniser chain; a depth of zero is for inputs that are already synchronous. Software finds pending work by ANDing the flags with the enables and scanning upward from bit 0. To initialise, it writes all ones to enable-clear and then all ones to the flag register.

Top module: `irq_gather_ctrl`

## Requirements
- R1: While `rst_n` is low and right after it rises, every enable bit and every pending flag is 0, `irq_out` is 0 and `bus_rdata` is 0.
- R2: A pending flag becomes 1 in any cycle in which its synchronised request is 1, whether or not the line is enabled. It stays 1 after the request falls, even for a one-cycle request pulse.
- R3: A write to byte offset 0x16 clears each pending flag whose data bit is 1. Flags whose data bit is 0 are unchanged. A read of 0x16 returns the pending flags, bit i for line i.
- R4: If a line's synchronised request is 1 in the same cycle as a clear write to its flag, the flag stays 1.
- R5: A write to offset 0x1A sets each enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x1A returns the enable vector.
- R6: A write to offset 0x1C clears each enable bit whose data bit is 1 and leaves the others unchanged. A read of 0x1C returns the enable vector and changes nothing.
- R7: A read of offset 0x18 returns the synchronised request lines as they are, with no latching and no masking.
- R8: `irq_out` is a register. It goes to 1 one clock after some line has both its flag and its enable set. It goes to 0 one clock after the last such pair is broken by a flag clear or an enable clear.
- R9: Read data appears on `bus_rdata` after the clock edge that samples a read (`bus_sel`=1, `bus_wr`=0) and holds until the next read. Unmapped offsets read 0. Writes to 0x18 or to unmapped offsets change nothing.
- R10: With SYNC_STAGES stages, a request that rises reaches its flag SYNC_STAGES+1 edges later and reaches `irq_out` SYNC_STAGES+2 edges later.
- R11: Writing 0xFFFF to 0x1C and then 0xFFFF to 0x16, with the requests low, leaves all enables and all flags at 0 and `irq_out` at 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| req_in | input | NSRC | Interrupt request lines, bit i is line i |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_wr | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | NSRC | Write data |
| bus_rdata | output | NSRC | Registered read data |
| irq_out | output | 1 | Combined interrupt, active high, level |

## Verification
Each result has a fixed place in time after its stimulus:
- A write lands on the edge that samples it, and read data is valid at the falling edge after the sampling edge.
- `irq_out` follows a flag clear or an enable clear one edge later.
- A request change needs SYNC_STAGES+2 edges to reach `irq_out`.

The vector table lets every step settle for four idle cycles after its access before checking `irq_out`. It changes the request lines only in steps that do not read the live view.

The directed tests count edges exactly. They check that `irq_out` is still high at the falling edge after a clearing write and low one cycle later, and that it is low for three cycles and high on the fourth after a request rises. They also put a clear write in the same cycle as a held request.

// File: rtl/irq_gather_pkg.sv
package irq_gather_pkg;

   typedef enum logic [2:0] {
      SEL_NONE,
      SEL_STAT,
      SEL_RAW,
      SEL_MSET,
      SEL_MCLR
   } reg_sel_e;

   localparam int unsigned MAX_SRC  = 32;
   localparam int unsigned MAX_SYNC = 4;

endpackage

// File: rtl/irq_gather_sync.sv
module irq_gather_sync #(
   parameter int unsigned WIDTH  = 16,
   parameter int unsigned STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);

   generate
      if (STAGES == 0) begin : g_bypass
         assign q = d;
      end else begin : g_chain
         logic [WIDTH-1:0] stg [STAGES];
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               for (int s = 0; s < STAGES; s++) stg[s] <= '0;
            end else begin
               stg[0] <= d;
               for (int s = 1; s < STAGES; s++) stg[s] <= stg[s-1];
            end
         end
         assign q = stg[STAGES-1];
      end
   endgenerate

endmodule

// File: rtl/irq_gather_flags.sv
module irq_gather_flags #(
   parameter int unsigned NSRC = 16
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic [NSRC-1:0] req_s,
   input  logic [NSRC-1:0] clr_pend,
   input  logic [NSRC-1:0] set_en,
   input  logic [NSRC-1:0] clr_en,
   output logic [NSRC-1:0] pend,
   output logic [NSRC-1:0] en
);

   for (genvar i = 0; i < NSRC; i++) begin : g_line
      logic pend_q;
      logic en_q;
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            pend_q <= 1'b0;
            en_q   <= 1'b0;
         end else begin
            pend_q <= req_s[i] | (pend_q & ~clr_pend[i]);
            en_q   <= set_en[i] | (en_q & ~clr_en[i]);
         end
      end
      assign pend[i] = pend_q;
      assign en[i]   = en_q;
   end

endmodule

// File: rtl/irq_gather_regs.sv
module irq_gather_regs
   import irq_gather_pkg::*;
#(
   parameter int unsigned          NSRC     = 16,
   parameter int unsigned          ADDR_W   = 8,
   parameter logic [ADDR_W-1:0]    OFS_STAT = 'h16,
   parameter logic [ADDR_W-1:0]    OFS_RAW  = 'h18,
   parameter logic [ADDR_W-1:0]    OFS_MSET = 'h1A,
   parameter logic [ADDR_W-1:0]    OFS_MCLR = 'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NSRC-1:0]   bus_wdata,
   input  logic [NSRC-1:0]   pend,
   input  logic [NSRC-1:0]   en,
   input  logic [NSRC-1:0]   req_s,
   output logic [NSRC-1:0]   clr_pend,
   output logic [NSRC-1:0]   set_en,
   output logic [NSRC-1:0]   clr_en,
   output logic [NSRC-1:0]   bus_rdata
);

   reg_sel_e         sel;
   logic             wr_stb;
   logic             rd_stb;
   logic [NSRC-1:0]  rd_mux;
   logic [NSRC-1:0]  rdata_q;

   always_comb begin
      sel = SEL_NONE;
      if (bus_addr == OFS_STAT)      sel = SEL_STAT;
      else if (bus_addr == OFS_RAW)  sel = SEL_RAW;
      else if (bus_addr == OFS_MSET) sel = SEL_MSET;
      else if (bus_addr == OFS_MCLR) sel = SEL_MCLR;
   end

   assign wr_stb = bus_sel &  bus_wr;
   assign rd_stb = bus_sel & ~bus_wr;

   assign clr_pend = (wr_stb && sel == SEL_STAT) ? bus_wdata : '0;
   assign set_en   = (wr_stb && sel == SEL_MSET) ? bus_wdata : '0;
   assign clr_en   = (wr_stb && sel == SEL_MCLR) ? bus_wdata : '0;

   always_comb begin
      case (sel)
         SEL_STAT:           rd_mux = pend;
         SEL_RAW:            rd_mux = req_s;
         SEL_MSET, SEL_MCLR: rd_mux = en;
         default:            rd_mux = '0;
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)      rdata_q <= '0;
      else if (rd_stb) rdata_q <= rd_mux;
   end

   assign bus_rdata = rdata_q;

endmodule

// File: rtl/irq_gather_ctrl.sv
module irq_gather_ctrl
   import irq_gather_pkg::*;
#(
   parameter int unsigned          NSRC        = 16,
   parameter int unsigned          ADDR_W      = 8,
   parameter int unsigned          SYNC_STAGES = 2,
   parameter logic [ADDR_W-1:0]    OFS_STAT    = 'h16,
   parameter logic [ADDR_W-1:0]    OFS_RAW     = 'h18,
   parameter logic [ADDR_W-1:0]    OFS_MSET    = 'h1A,
   parameter logic [ADDR_W-1:0]    OFS_MCLR    = 'h1C
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [NSRC-1:0]   req_in,
   input  logic              bus_sel,
   input  logic              bus_wr,
   input  logic [ADDR_W-1:0] bus_addr,
   input  logic [NSRC-1:0]   bus_wdata,
   output logic [NSRC-1:0]   bus_rdata,
   output logic              irq_out
);

   generate
      if (NSRC < 1 || NSRC > MAX_SRC) begin : g_bad_nsrc
         $error("irq_gather_ctrl: NSRC out of range");
      end
      if (SYNC_STAGES > MAX_SYNC) begin : g_bad_sync
         $error("irq_gather_ctrl: SYNC_STAGES too deep");
      end
      if (OFS_STAT == OFS_RAW || OFS_STAT == OFS_MSET || OFS_STAT == OFS_MCLR ||
          OFS_RAW == OFS_MSET || OFS_RAW == OFS_MCLR || OFS_MSET == OFS_MCLR) begin : g_bad_ofs
         $error("irq_gather_ctrl: register offsets overlap");
      end
   endgenerate

   logic [NSRC-1:0] req_s_w;
   logic [NSRC-1:0] pend_w;
   logic [NSRC-1:0] en_w;
   logic [NSRC-1:0] clr_pend_w;
   logic [NSRC-1:0] set_en_w;
   logic [NSRC-1:0] clr_en_w;
   logic            irq_q;

   irq_gather_sync #(.WIDTH(NSRC), .STAGES(SYNC_STAGES)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     (req_in),
      .q     (req_s_w)
   );

   irq_gather_regs #(
      .NSRC(NSRC), .ADDR_W(ADDR_W),
      .OFS_STAT(OFS_STAT), .OFS_RAW(OFS_RAW),
      .OFS_MSET(OFS_MSET), .OFS_MCLR(OFS_MCLR)
   ) u_regs (
      .clk       (clk),
      .rst_n     (rst_n),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .pend      (pend_w),
      .en        (en_w),
      .req_s     (req_s_w),
      .clr_pend  (clr_pend_w),
      .set_en    (set_en_w),
      .clr_en    (clr_en_w),
      .bus_rdata (bus_rdata)
   );

   irq_gather_flags #(.NSRC(NSRC)) u_flags (
      .clk      (clk),
      .rst_n    (rst_n),
      .req_s    (req_s_w),
      .clr_pend (clr_pend_w),
      .set_en   (set_en_w),
      .clr_en   (clr_en_w),
      .pend     (pend_w),
      .en       (en_w)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) irq_q <= 1'b0;
      else        irq_q <= |(pend_w & en_w);
   end

   assign irq_out = irq_q;

endmodule

// File: rtl/irq_gather_chk.sv
module irq_gather_chk #(
   parameter int unsigned NSRC = 16
) (
   input logic            clk,
   input logic            rst_n,
   input logic            irq_out,
   input logic [NSRC-1:0] pend,
   input logic [NSRC-1:0] en,
   input logic [NSRC-1:0] req_s,
   input logic [NSRC-1:0] clr_pend,
   input logic [NSRC-1:0] set_en,
   input logic [NSRC-1:0] clr_en
);

   logic armed;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   assert_reset_state_R1: assert property (@(posedge clk)
      !rst_n |-> (pend == '0 && en == '0 && !irq_out));

   assert_flag_latch_R2: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pend & $past(req_s)) == $past(req_s)));

   assert_w1c_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pend & $past(clr_pend) & ~$past(req_s)) == '0));

   assert_flag_sticky_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(clr_pend) == '0) |-> ((pend & $past(pend)) == $past(pend)));

   assert_set_wins_R4: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((pend & $past(clr_pend & req_s)) == $past(clr_pend & req_s)));

   assert_w1s_enable_R5: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((en & $past(set_en)) == $past(set_en)));

   assert_enable_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && $past(set_en) == '0 && $past(clr_en) == '0) |-> (en == $past(en)));

   assert_w1c_enable_R6: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> ((en & $past(clr_en)) == '0));

   assert_irq_level_R8: assert property (@(posedge clk) disable iff (!rst_n)
      armed |-> (irq_out == |($past(pend) & $past(en))));

   assert_one_target_R9: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({|clr_pend, |set_en, |clr_en}));

endmodule

bind irq_gather_ctrl irq_gather_chk #(.NSRC(NSRC)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .irq_out  (irq_out),
   .pend     (pend_w),
   .en       (en_w),
   .req_s    (req_s_w),
   .clr_pend (clr_pend_w),
   .set_en   (set_en_w),
   .clr_en   (clr_en_w)
);

// File: tb/test_irq_gather_ctrl.sv
module test_irq_gather_ctrl;

   localparam int unsigned CLK_PERIOD = 10;
   localparam int unsigned NSRC       = 16;
   localparam int unsigned ADDR_W     = 8;
   localparam int unsigned SYNC       = 2;
   localparam int unsigned LAT        = SYNC + 2;
   localparam int unsigned SETTLE     = 4;

   localparam logic [1:0] OP_IDLE = 2'd0;
   localparam logic [1:0] OP_WR   = 2'd1;
   localparam logic [1:0] OP_RD   = 2'd2;

   typedef struct packed {
      logic [1:0]  op;
      logic [7:0]  addr;
      logic [15:0] data;
      logic [15:0] req;
      logic [15:0] exp;
      logic        irq;
   } vec_t;

   localparam int NV = 24;
   localparam vec_t VEC [NV] = '{
      '{OP_IDLE, 8'h00, 16'h0000, 16'h0005, 16'h0000, 1'b0},  // R2 latch while disabled
      '{OP_RD,   8'h16, 16'h0000, 16'h0005, 16'h0005, 1'b0},  // R2 R3
      '{OP_RD,   8'h18, 16'h0000, 16'h0005, 16'h0005, 1'b0},  // R7
      '{OP_WR,   8'h1A, 16'h0004, 16'h0000, 16'h0000, 1'b1},  // R5 R8
      '{OP_RD,   8'h1A, 16'h0000, 16'h0000, 16'h0004, 1'b1},  // R5
      '{OP_RD,   8'h18, 16'h0000, 16'h0000, 16'h0000, 1'b1},  // R7 not latched
      '{OP_RD,   8'h16, 16'h0000, 16'h0000, 16'h0005, 1'b1},  // R2 sticky
      '{OP_WR,   8'h16, 16'h0004, 16'h0000, 16'h0000, 1'b0},  // R3 R8
      '{OP_RD,   8'h16, 16'h0000, 16'h0000, 16'h0001, 1'b0},  // R3
      '{OP_WR,   8'h16, 16'h0000, 16'h0000, 16'h0000, 1'b0},  // R3 zero bits
      '{OP_RD,   8'h16, 16'h0000, 16'h0000, 16'h0001, 1'b0},  // R3
      '{OP_WR,   8'h1A, 16'h8001, 16'h0000, 16'h0000, 1'b1},  // R5 R8
      '{OP_WR,   8'h1C, 16'h0001, 16'h0000, 16'h0000, 1'b0},  // R6 R8
      '{OP_RD,   8'h1C, 16'h0000, 16'h0000, 16'h8004, 1'b0},  // R6
      '{OP_RD,   8'h1A, 16'h0000, 16'h0000, 16'h8004, 1'b0},  // R6 no side effect
      '{OP_WR,   8'h18, 16'hFFFF, 16'h0000, 16'h0000, 1'b0},  // R9 ignored write
      '{OP_RD,   8'h16, 16'h0000, 16'h0000, 16'h0001, 1'b0},  // R9
      '{OP_RD,   8'h1A, 16'h0000, 16'h0000, 16'h8004, 1'b0},  // R9
      '{OP_RD,   8'h00, 16'h0000, 16'h0000, 16'h0000, 1'b0},  // R9 unmapped
      '{OP_IDLE, 8'h00, 16'h0000, 16'h8000, 16'h0000, 1'b1},  // R8
      '{OP_WR,   8'h1C, 16'hFFFF, 16'h0000, 16'h0000, 1'b0},  // R11
      '{OP_WR,   8'h16, 16'hFFFF, 16'h0000, 16'h0000, 1'b0},  // R11
      '{OP_RD,   8'h16, 16'h0000, 16'h0000, 16'h0000, 1'b0},  // R11
      '{OP_RD,   8'h1A, 16'h0000, 16'h0000, 16'h0000, 1'b0}   // R11
   };

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic [NSRC-1:0]   req_in = '0;
   logic              bus_sel = 1'b0;
   logic              bus_wr = 1'b0;
   logic [ADDR_W-1:0] bus_addr = '0;
   logic [NSRC-1:0]   bus_wdata = '0;
   logic [NSRC-1:0]   bus_rdata;
   logic              irq_out;

   int n_chk  = 0;
   int n_fail = 0;
   bit done   = 1'b0;
   logic [NSRC-1:0] rd_val;

   always #(CLK_PERIOD/2) clk = ~clk;

   irq_gather_ctrl #(
      .NSRC(NSRC), .ADDR_W(ADDR_W), .SYNC_STAGES(SYNC)
   ) i_irq_gather_ctrl (
      .clk       (clk),
      .rst_n     (rst_n),
      .req_in    (req_in),
      .bus_sel   (bus_sel),
      .bus_wr    (bus_wr),
      .bus_addr  (bus_addr),
      .bus_wdata (bus_wdata),
      .bus_rdata (bus_rdata),
      .irq_out   (irq_out)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   // called at a falling edge; returns at the falling edge after the sampling edge
   task automatic bus_write(input logic [7:0] a, input logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
   endtask

   task automatic bus_read(input logic [7:0] a, output logic [15:0] d);
      bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
      @(negedge clk);
      bus_sel = 1'b0;
      d = bus_rdata;
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_fail++;
         $display("FAIL watchdog: actual timeout expected completion");
         $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
         $finish;
      end
   end

   initial begin
      // R1 reset state
      repeat (3) @(negedge clk);
      check("R1 irq in reset", {31'd0, irq_out}, 32'd0);
      check("R1 rdata in reset", {16'd0, bus_rdata}, 32'd0);
      rst_n = 1'b1;
      @(negedge clk);
      bus_read(8'h16, rd_val); check("R1 flags after reset", {16'd0, rd_val}, 32'd0);
      bus_read(8'h1A, rd_val); check("R1 enables after reset", {16'd0, rd_val}, 32'd0);
      check("R1 irq after reset", {31'd0, irq_out}, 32'd0);

      // vector table
      for (int k = 0; k < NV; k++) begin
         req_in = VEC[k].req;
         rd_val = '0;
         case (VEC[k].op)
            OP_WR:   bus_write(VEC[k].addr, VEC[k].data);
            OP_RD:   bus_read(VEC[k].addr, rd_val);
            default: @(negedge clk);
         endcase
         repeat (SETTLE) @(negedge clk);
         if (VEC[k].op == OP_RD)
            check($sformatf("R2-7/R9/R11 vector %0d rdata", k), {16'd0, rd_val}, {16'd0, VEC[k].exp});
         check($sformatf("R8 vector %0d irq", k), {31'd0, irq_out}, {31'd0, VEC[k].irq});
      end

      // R4: clear write while request held high
      req_in = 16'h0008;
      repeat (SETTLE) @(negedge clk);
      bus_write(8'h16, 16'h0008);
      bus_read(8'h16, rd_val); check("R4 set wins over clear", {16'd0, rd_val}, 32'h0008);
      req_in = '0;
      repeat (SETTLE) @(negedge clk);
      bus_write(8'h16, 16'h0008);
      bus_read(8'h16, rd_val); check("R3 clear after request falls", {16'd0, rd_val}, 32'h0000);

      // R10: request-to-output latency
      bus_write(8'h1A, 16'h0020);
      req_in = 16'h0020;
      for (int c = 1; c <= LAT; c++) begin
         @(negedge clk);
         check($sformatf("R10 irq after %0d edges", c), {31'd0, irq_out}, (c == LAT) ? 32'd1 : 32'd0);
      end
      req_in = '0;
      repeat (SETTLE) @(negedge clk);

      // R8: output falls one edge after the clearing write
      bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = 8'h16; bus_wdata = 16'h0020;
      @(negedge clk);
      bus_sel = 1'b0; bus_wr = 1'b0;
      check("R8 irq still high at write edge", {31'd0, irq_out}, 32'd1);
      @(negedge clk);
      check("R8 irq low one edge later", {31'd0, irq_out}, 32'd0);

      // R2: one-cycle pulse on a disabled line is kept
      req_in = 16'h0200;
      @(negedge clk);
      req_in = '0;
      repeat (SETTLE) @(negedge clk);
      bus_read(8'h16, rd_val); check("R2 pulse latched", {16'd0, rd_val}, 32'h0200);
      bus_read(8'h18, rd_val); check("R7 live view low", {16'd0, rd_val}, 32'h0000);
      check("R8 disabled line gives no irq", {31'd0, irq_out}, 32'd0);

      done = 1'b1;
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

endmodule